// File: doc/BRIEF.md
# USB Device Control and Interrupt Flag Registers

This block holds two byte-wide registers of a USB device controller: a control register and a device-level interrupt flag register. A CPU reaches both over a simple byte bus with an address, a write enable, write data and combinational read data. The control register drives the D+ pull-up enable, issues a one-cycle upstream-resume request strobe, and arms a CPU and peripheral reset that fires on a USB bus reset.

The USB engine sends single-cycle event pulses into the block. Each pulse sets its own flag. Software acknowledges a flag by writing zero to its bit. Writing one to a flag bit leaves it unchanged. Per-source enable bits arrive as an input vector that uses the same bit positions as the flag register. Any flag that is set and enabled raises the combined interrupt output.

The control register sits at address 0xE0 and the flag register at 0xE1. Both addresses are parameters.

Top module: `usb_dev_regs`

## Requirements
- R1: After reset the control register reads 0x01 and the flag register reads 0x00. pullup_en_o, rsm_req_o, cpu_rst_req_o and irq_o are all low.
- R2: The control register at 0xE0 reads as {5'b0, rst_arm, 1'b0, detach}. Bits 7:3 always read zero, and writes to them are ignored.
- R3: pullup_en_o is the inverse of detach (bit 0). Writing 0 to bit 0 attaches the device. Writing 1 detaches it.
- R4: A write of 1 to control bit 1 raises rsm_req_o for exactly one cycle, in the cycle after the write. Writing 0 to that bit has no effect. Bit 1 always reads zero.
- R5: cpu_rst_req_o is high in exactly the cycles where bus_reset_i is high while rst_arm (bit 2) is set. It is a single-cycle pulse for a single-cycle bus reset.
- R6: rst_arm is cleared while usb_en_i is low, and that clear overrides a write. Otherwise rst_arm takes bit 2 of any control write.
- R7: The flag register at 0xE1 has bits 7 and 1 reserved, reading zero. An event pulse sets its flag in the next cycle: bit 6 from uprsm_evt_i, bit 5 from eorsm_evt_i, bit 4 from aux_evt_i[2] (wake-up), bit 3 from bus_reset_i (end of reset), bit 2 from aux_evt_i[1] (start of frame), and bit 0 from aux_evt_i[0] (suspend).
- R8: A flag-register write clears each flag whose written bit is 0 and leaves each flag whose written bit is 1 unchanged.
- R9: When a set event and a write-zero clear hit the same flag in the same cycle, the flag ends up set.
- R10: irq_o is high exactly when some flag bit and the same bit of irq_en_i are both one.
- R11: Any other address reads 0x00, and writes to it change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | CPU bus address |
| we_i | input | 1 | CPU write enable |
| wdata_i | input | 8 | CPU write data |
| rdata_o | output | 8 | CPU read data, combinational |
| usb_en_i | input | 1 | USB controller enabled |
| uprsm_evt_i | input | 1 | Pulse: upstream resume has been sent |
| eorsm_evt_i | input | 1 | Pulse: host end of resume detected |
| bus_reset_i | input | 1 | Pulse: USB bus reset detected |
| aux_evt_i | input | 3 | Pulses: wake-up [2], start of frame [1], suspend [0] |
| irq_en_i | input | 8 | Per-flag interrupt enables, same bit positions as the flag register |
| pullup_en_o | output | 1 | D+ pull-up enable |
| rsm_req_o | output | 1 | One-cycle upstream-resume request |
| cpu_rst_req_o | output | 1 | CPU and peripheral reset request |
| irq_o | output | 1 | Combined USB general interrupt |

## Verification
The properties assume that the event inputs and the bus signals are settled at each rising edge. They also assume that reset is held from time zero until the first edges. The bench drives every input at the falling clock edge and holds reset low for the first cycles. The random stimulus keeps events sparse and mixes in writes to the flag register that collide with events. It also includes stretches with usb_en_i low and accesses to unmapped addresses, so that every property condition is reached with legal input timing.

// File: rtl/usb_dev_pkg.sv
package usb_dev_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 8;

  // flag register bit positions
  localparam int unsigned FB_UPRSM  = 6;
  localparam int unsigned FB_EORSM  = 5;
  localparam int unsigned FB_WAKE   = 4;
  localparam int unsigned FB_EORST  = 3;
  localparam int unsigned FB_SOF    = 2;
  localparam int unsigned FB_SUSP   = 0;
  localparam logic [DATA_W-1:0] FLAG_MASK = 8'h7D;

  // control register bit positions
  localparam int unsigned CB_DETACH = 0;
  localparam int unsigned CB_RSM    = 1;
  localparam int unsigned CB_ARM    = 2;
endpackage

// File: rtl/usb_ctrl_reg.sv
module usb_ctrl_reg (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [2:0] wdata_i,
  input  logic       usb_en_i,
  input  logic       bus_reset_i,
  output logic       detach_o,
  output logic       arm_o,
  output logic       rsm_req_o,
  output logic       cpu_rst_req_o
);
  import usb_dev_pkg::*;

  logic detach_q, arm_q, rsm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      detach_q <= 1'b1;
      arm_q    <= 1'b0;
      rsm_q    <= 1'b0;
    end else begin
      if (wr_i) detach_q <= wdata_i[CB_DETACH];
      // controller disable overrides any write
      if (!usb_en_i)  arm_q <= 1'b0;
      else if (wr_i)  arm_q <= wdata_i[CB_ARM];
      rsm_q <= wr_i & wdata_i[CB_RSM];
    end
  end

  assign detach_o      = detach_q;
  assign arm_o         = arm_q;
  assign rsm_req_o     = rsm_q;
  assign cpu_rst_req_o = arm_q & bus_reset_i;
endmodule

// File: rtl/usb_int_flags.sv
module usb_int_flags #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] set_i,
  output logic [W-1:0] flag_o
);
  logic [W-1:0] flag_q, clr;

  assign clr = wr_i ? ~wdata_i : '0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (MASK[i]) begin : g_impl
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       flag_q[i] <= 1'b0;
        else if (set_i[i]) flag_q[i] <= 1'b1;  // set wins over clear
        else if (clr[i])   flag_q[i] <= 1'b0;
      end
    end else begin : g_rsvd
      assign flag_q[i] = 1'b0;
      logic unused_b;
      assign unused_b = clr[i] ^ set_i[i];
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/usb_dev_regs.sv
module usb_dev_regs #(
  parameter logic [7:0] CTRL_ADDR = 8'hE0,
  parameter logic [7:0] FLAG_ADDR = 8'hE1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] addr_i,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       usb_en_i,
  input  logic       uprsm_evt_i,
  input  logic       eorsm_evt_i,
  input  logic       bus_reset_i,
  input  logic [2:0] aux_evt_i,
  input  logic [7:0] irq_en_i,
  output logic       pullup_en_o,
  output logic       rsm_req_o,
  output logic       cpu_rst_req_o,
  output logic       irq_o
);
  import usb_dev_pkg::*;

  logic       ctrl_wr, flag_wr;
  logic       detach_q, rst_arm_q;
  logic [7:0] flag_set, flag_q;

  assign ctrl_wr = we_i && (addr_i == CTRL_ADDR);
  assign flag_wr = we_i && (addr_i == FLAG_ADDR);

  usb_ctrl_reg u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (ctrl_wr),
    .wdata_i      (wdata_i[2:0]),
    .usb_en_i     (usb_en_i),
    .bus_reset_i  (bus_reset_i),
    .detach_o     (detach_q),
    .arm_o        (rst_arm_q),
    .rsm_req_o    (rsm_req_o),
    .cpu_rst_req_o(cpu_rst_req_o)
  );

  always_comb begin
    flag_set           = '0;
    flag_set[FB_UPRSM] = uprsm_evt_i;
    flag_set[FB_EORSM] = eorsm_evt_i;
    flag_set[FB_WAKE]  = aux_evt_i[2];
    flag_set[FB_EORST] = bus_reset_i;
    flag_set[FB_SOF]   = aux_evt_i[1];
    flag_set[FB_SUSP]  = aux_evt_i[0];
  end

  usb_int_flags #(.W(DATA_W), .MASK(FLAG_MASK)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (flag_wr),
    .wdata_i(wdata_i),
    .set_i  (flag_set),
    .flag_o (flag_q)
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i == CTRL_ADDR) begin
      rdata_o[CB_DETACH] = detach_q;
      rdata_o[CB_ARM]    = rst_arm_q;
    end else if (addr_i == FLAG_ADDR) begin
      rdata_o = flag_q;
    end
  end

  assign pullup_en_o = ~detach_q;
  assign irq_o       = |(flag_q & irq_en_i);
endmodule

// File: rtl/usb_dev_regs_chk.sv
module usb_dev_regs_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] addr_i,
  input logic       we_i,
  input logic [7:0] wdata_i,
  input logic [7:0] rdata_o,
  input logic       usb_en_i,
  input logic       uprsm_evt_i,
  input logic       eorsm_evt_i,
  input logic       bus_reset_i,
  input logic [7:0] irq_en_i,
  input logic       pullup_en_o,
  input logic       rsm_req_o,
  input logic       cpu_rst_req_o,
  input logic       irq_o,
  input logic [7:0] flag_q,
  input logic       rst_arm_q
);
  localparam logic [7:0] CA = 8'hE0;
  localparam logic [7:0] FA = 8'hE1;

  p_ctrl_rsvd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == CA) |-> (rdata_o[7:3] == 5'd0 && !rdata_o[1]));

  p_attach_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pullup_en_o) |-> $past(we_i && addr_i == CA && !wdata_i[0]));

  p_rsm_fire_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == CA && wdata_i[1]) |=> rsm_req_o);

  p_rsm_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == CA && wdata_i[1]) |=> !rsm_req_o);

  p_rst_req_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rst_req_o |-> (bus_reset_i && rst_arm_q));

  p_arm_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !usb_en_i |=> !rst_arm_q);

  p_flag_rsvd_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_q[7] && !flag_q[1]));

  p_eorst_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_reset_i |=> flag_q[3]);

  p_keep_one_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == FA && wdata_i[5] && flag_q[5]) |=> flag_q[5]);

  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == FA && !wdata_i[5] && !eorsm_evt_i) |=> !flag_q[5]);

  p_set_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == FA && !wdata_i[6] && uprsm_evt_i) |=> flag_q[6]);

  p_irq_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flag_q & irq_en_i) != 8'd0) |-> irq_o);
endmodule

bind usb_dev_regs usb_dev_regs_chk u_chk (.*);

// File: tb/usb_dev_regs_test.sv
`timescale 1ns/1ps
module usb_dev_regs_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] addr_i = 8'h00;
  logic       we_i = 1'b0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic       usb_en_i = 1'b1;
  logic       uprsm_evt_i = 1'b0, eorsm_evt_i = 1'b0, bus_reset_i = 1'b0;
  logic [2:0] aux_evt_i = 3'b000;
  logic [7:0] irq_en_i = 8'h00;
  logic       pullup_en_o, rsm_req_o, cpu_rst_req_o, irq_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // model state
  logic       m_detach = 1'b1, m_arm = 1'b0, m_rsm = 1'b0;
  logic [7:0] m_flags = 8'h00;

  always #10 clk = ~clk;

  usb_dev_regs uut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .usb_en_i(usb_en_i),
    .uprsm_evt_i(uprsm_evt_i), .eorsm_evt_i(eorsm_evt_i),
    .bus_reset_i(bus_reset_i), .aux_evt_i(aux_evt_i), .irq_en_i(irq_en_i),
    .pullup_en_o(pullup_en_o), .rsm_req_o(rsm_req_o),
    .cpu_rst_req_o(cpu_rst_req_o), .irq_o(irq_o)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_read(logic [7:0] a);
    if (a == 8'hE0) return {5'b0, m_arm, 1'b0, m_detach};   // R2
    if (a == 8'hE1) return m_flags;                         // R7
    return 8'h00;                                           // R11
  endfunction

  function automatic logic [7:0] set_vec();
    logic [7:0] s = 8'h00;
    s[6] = uprsm_evt_i; s[5] = eorsm_evt_i; s[4] = aux_evt_i[2];
    s[3] = bus_reset_i; s[2] = aux_evt_i[1]; s[0] = aux_evt_i[0];
    return s;
  endfunction

  // check outputs for the current inputs, then advance model one clock
  task automatic cycle();
    logic [7:0] clr;
    #1;
    chk((addr_i == 8'hE0) ? "R2" : (addr_i == 8'hE1) ? "R7" : "R11",
        rdata_o, exp_read(addr_i));
    chk("R3", {7'b0, pullup_en_o}, {7'b0, ~m_detach});
    chk("R4", {7'b0, rsm_req_o}, {7'b0, m_rsm});
    chk("R5", {7'b0, cpu_rst_req_o}, {7'b0, m_arm & bus_reset_i});
    chk("R10", {7'b0, irq_o}, {7'b0, |(m_flags & irq_en_i)});
    clr = (we_i && addr_i == 8'hE1) ? ~wdata_i : 8'h00;      // R8
    m_rsm = we_i && addr_i == 8'hE0 && wdata_i[1];
    if (!usb_en_i) m_arm = 1'b0;                             // R6
    else if (we_i && addr_i == 8'hE0) m_arm = wdata_i[2];
    if (we_i && addr_i == 8'hE0) m_detach = wdata_i[0];
    m_flags = ((m_flags & ~clr) | set_vec()) & 8'h7D;        // R9 set wins
    @(negedge clk);
  endtask

  task automatic idle();
    we_i = 0; uprsm_evt_i = 0; eorsm_evt_i = 0; bus_reset_i = 0; aux_evt_i = 0;
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    idle(); addr_i = a; we_i = 1; wdata_i = d; cycle(); we_i = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed = 32'd20240611;
    void'($urandom(seed));
    // R1: reset state
    repeat (3) @(negedge clk);
    addr_i = 8'hE0; #1; chk("R1", rdata_o, 8'h01);
    addr_i = 8'hE1; #1; chk("R1", rdata_o, 8'h00);
    chk("R1", {4'b0, pullup_en_o, rsm_req_o, cpu_rst_req_o, irq_o}, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk);

    // R2 reserved writes ignored, R3 attach
    wr(8'hE0, 8'hF8);
    addr_i = 8'hE0; cycle();
    // R4 wake request strobe and read-zero
    wr(8'hE0, 8'h02);
    addr_i = 8'hE0; cycle(); cycle();
    // R5 armed bus reset pulse
    wr(8'hE0, 8'h04);
    bus_reset_i = 1; cycle(); bus_reset_i = 0; cycle();
    // R6 disable clears arm, write ignored meanwhile
    usb_en_i = 0; wr(8'hE0, 8'h04); addr_i = 8'hE0; cycle(); usb_en_i = 1;
    wr(8'hE0, 8'h04); wr(8'hE0, 8'h00); addr_i = 8'hE0; cycle();
    // R7 each event, R8 write one keeps then zero clears
    irq_en_i = 8'h00;
    uprsm_evt_i = 1; eorsm_evt_i = 1; aux_evt_i = 3'b111; addr_i = 8'hE1; cycle();
    idle(); cycle();
    wr(8'hE1, 8'hFF); addr_i = 8'hE1; cycle();
    wr(8'hE1, 8'hDF); addr_i = 8'hE1; cycle();
    // R9 set and clear collide
    addr_i = 8'hE1; we_i = 1; wdata_i = 8'h00; uprsm_evt_i = 1; cycle();
    idle(); cycle();
    // R10 enable mapping
    irq_en_i = 8'h40; cycle(); irq_en_i = 8'h20; cycle();
    // R11 unmapped address
    wr(8'hE2, 8'h00); wr(8'h61, 8'h00); addr_i = 8'hE1; cycle();

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      int unsigned r = $urandom % 8;
      addr_i = (r < 3) ? 8'hE0 : (r < 6) ? 8'hE1 : 8'($urandom);
      we_i = ($urandom % 3) == 0;
      wdata_i = 8'($urandom);
      usb_en_i = ($urandom % 16) != 0;
      uprsm_evt_i = ($urandom % 8) == 0;
      eorsm_evt_i = ($urandom % 8) == 0;
      bus_reset_i = ($urandom % 8) == 0;
      aux_evt_i = {($urandom % 8) == 0, ($urandom % 8) == 0, ($urandom % 8) == 0};
      irq_en_i = 8'($urandom);
      cycle();
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule